// File: doc/BRIEF.md
# Pipeline Register with Diagnostic Scan Shadow

This block is an 8-bit register that sits in a normal data path. A second 8-bit shadow register sits beside it for diagnostics. The two registers run on separate clocks. The pipeline clock updates the data-path register. The diagnostic clock updates the shadow. One mode input and the serial input together choose what each clock edge does.

In normal operation the mode input is low. The pipeline register takes its value from the parallel data pins, and the shadow acts as a serial shift register inside a scan loop.

A diagnostic controller uses the block in two directions:
- To force a known value into the data path, it shifts the byte into the shadow and then transfers it into the pipeline register.
- To observe the data path, it captures the pipeline value into the shadow and shifts it out serially.

The shadow can also hold its value and drive it back onto the bidirectional data pins. The pins are modelled as separate in, out and enable signals. The registered outputs are modelled as data plus a drive-enable flag controlled by an active-low output enable.

Top module: `scan_pipe_reg`

## Requirements
- R1: When `prst_n` is low, the pipeline register is cleared to zero asynchronously. When `drst_n` is low, the shadow register is cleared to zero asynchronously. Each reset leaves the other register unchanged.
- R2: With `mode` low, a rising `dclk` shifts the shadow toward its MSB: bit 0 takes `sdi` and bit i takes the old bit i-1.
- R3: With `mode` low, a rising `pclk` loads `din` into the pipeline register.
- R4: With `mode` high, a rising `pclk` loads the pipeline register from the shadow register.
- R5: With `mode` high and `sdi` low, a rising `dclk` loads the shadow with the pipeline register value. The value is taken from the register itself, whatever the state of `oe_n`.
- R6: With `mode` high and `sdi` high, a rising `dclk` leaves the shadow unchanged. In this setting `dout_en` is 1 and `dout` equals the shadow. In every other setting `dout_en` is 0.
- R7: `y` always equals the pipeline register. `y_en` is 1 exactly when `oe_n` is 0.
- R8: `sdo` equals shadow bit 7 when `mode` is low. It equals `sdi`, combinationally, when `mode` is high.
- R9: When `pclk` and `dclk` rise together with `mode` high and `sdi` low, the two registers swap their pre-edge values.
- R10: A full diagnostic round trip works end to end:
  - a byte shifted in MSB first and transferred to the pipeline appears on `y`;
  - a pipeline value captured into the shadow and shifted out appears on `sdo` MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Pipeline register clock |
| prst_n | input | 1 | Active-low async reset, pipeline domain |
| dclk | input | 1 | Diagnostic (shadow) clock |
| drst_n | input | 1 | Active-low async reset, shadow domain |
| mode | input | 1 | Operation select |
| sdi | input | 1 | Serial input; also sub-mode select when mode is high |
| din | input | 8 | Data pins, input side |
| dout | output | 8 | Data pins, output side (shadow contents) |
| dout_en | output | 1 | Data pin drive enable |
| oe_n | input | 1 | Active-low enable for registered outputs |
| y | output | 8 | Registered outputs |
| y_en | output | 1 | Registered output drive enable |
| sdo | output | 1 | Serial output |

## Verification
Two transfers can happen in the same cycle: the pipeline register loading from the shadow on `pclk`, and the shadow capturing the pipeline register on `dclk`. The bench first places distinct values in the two registers. It then raises both clocks in the same time step with `mode` high and `sdi` low. It passes only if `y` shows the shadow's old value and the shadow, read back through the hold path on `dout`, shows the pipeline's old value. A race in either direction would duplicate one of the two values instead of swapping them.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [1:0] {
    SH_SHIFT   = 2'd0,
    SH_CAPTURE = 2'd1,
    SH_HOLD    = 2'd2
  } shadow_op_e;

  function automatic shadow_op_e decode_shadow(input logic mode, input logic sdi);
    if (!mode)     return SH_SHIFT;
    else if (!sdi) return SH_CAPTURE;
    else           return SH_HOLD;
  endfunction
endpackage

// File: rtl/scan_pipe_stage.sv
module scan_pipe_stage #(
  parameter int W = 8
) (
  input  logic         pclk,
  input  logic         prst_n,
  input  logic         mode,
  input  logic [W-1:0] din,
  input  logic [W-1:0] shadow_q,
  output logic [W-1:0] pipe_q,
  output logic         from_shadow_evt
);
  logic [W-1:0] pipe_d;

  // event wire: next pclk edge reads the shadow
  assign from_shadow_evt = mode;

  always_comb begin
    if (from_shadow_evt) pipe_d = shadow_q;
    else                 pipe_d = din;
  end

  always_ff @(posedge pclk or negedge prst_n) begin
    if (!prst_n) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end
endmodule

// File: rtl/scan_shadow_stage.sv
module scan_shadow_stage
  import scan_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         dclk,
  input  logic         drst_n,
  input  shadow_op_e   op,
  input  logic         sdi,
  input  logic [W-1:0] pipe_q,
  output logic [W-1:0] shadow_q
);
  function automatic logic [W-1:0] shift_up(input logic [W-1:0] cur, input logic bit_in);
    return {cur[W-2:0], bit_in};
  endfunction

  logic [W-1:0] shadow_d;

  always_comb begin
    unique case (op)
      SH_SHIFT:   shadow_d = shift_up(shadow_q, sdi);
      SH_CAPTURE: shadow_d = pipe_q;
      default:    shadow_d = shadow_q;
    endcase
  end

  always_ff @(posedge dclk or negedge drst_n) begin
    if (!drst_n) shadow_q <= '0;
    else         shadow_q <= shadow_d;
  end
endmodule

// File: rtl/scan_pin_ctrl.sv
module scan_pin_ctrl
  import scan_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         mode,
  input  logic         sdi,
  input  shadow_op_e   op,
  input  logic         oe_n,
  input  logic [W-1:0] pipe_q,
  input  logic [W-1:0] shadow_q,
  output logic [W-1:0] dout,
  output logic         dout_en,
  output logic [W-1:0] y,
  output logic         y_en,
  output logic         sdo
);
  assign dout    = shadow_q;
  assign dout_en = (op == SH_HOLD);
  assign y       = pipe_q;
  assign y_en    = ~oe_n;
  // chained devices: pass sdi straight through in parallel modes
  assign sdo     = mode ? sdi : shadow_q[W-1];
endmodule

// File: rtl/scan_pipe_reg.sv
module scan_pipe_reg
  import scan_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         pclk,
  input  logic         prst_n,
  input  logic         dclk,
  input  logic         drst_n,
  input  logic         mode,
  input  logic         sdi,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         dout_en,
  input  logic         oe_n,
  output logic [W-1:0] y,
  output logic         y_en,
  output logic         sdo
);
  logic [W-1:0] pipe_q;
  logic [W-1:0] shadow_q;
  logic         from_shadow_evt;
  shadow_op_e   sh_op;

  assign sh_op = decode_shadow(mode, sdi);

  scan_pipe_stage #(.W(W)) pipe_i (
    .pclk(pclk), .prst_n(prst_n), .mode(mode), .din(din),
    .shadow_q(shadow_q), .pipe_q(pipe_q), .from_shadow_evt(from_shadow_evt)
  );

  scan_shadow_stage #(.W(W)) shadow_i (
    .dclk(dclk), .drst_n(drst_n), .op(sh_op), .sdi(sdi),
    .pipe_q(pipe_q), .shadow_q(shadow_q)
  );

  scan_pin_ctrl #(.W(W)) pins_i (
    .mode(mode), .sdi(sdi), .op(sh_op), .oe_n(oe_n),
    .pipe_q(pipe_q), .shadow_q(shadow_q),
    .dout(dout), .dout_en(dout_en), .y(y), .y_en(y_en), .sdo(sdo)
  );
endmodule

// File: rtl/scan_pipe_reg_chk.sv
module scan_pipe_reg_chk #(
  parameter int W = 8
) (
  input logic         pclk,
  input logic         prst_n,
  input logic         dclk,
  input logic         drst_n,
  input logic         mode,
  input logic         sdi,
  input logic [W-1:0] din,
  input logic [W-1:0] dout,
  input logic         dout_en,
  input logic         oe_n,
  input logic [W-1:0] y,
  input logic         y_en,
  input logic         sdo,
  input logic [W-1:0] pipe_q,
  input logic [W-1:0] shadow_q
);
  logic p_live, d_live;

  always_ff @(posedge pclk or negedge prst_n)
    if (!prst_n) p_live <= 1'b0; else p_live <= 1'b1;

  always_ff @(posedge dclk or negedge drst_n)
    if (!drst_n) d_live <= 1'b0; else d_live <= 1'b1;

  p_reset_p_r1: assert property (@(posedge pclk) !prst_n |-> pipe_q == '0);
  p_reset_d_r1: assert property (@(posedge dclk) !drst_n |-> shadow_q == '0);

  p_shift_r2: assert property (@(posedge dclk) disable iff (!drst_n)
    (d_live && !$past(mode)) |-> shadow_q == {$past(shadow_q[W-2:0]), $past(sdi)});

  p_load_din_r3: assert property (@(posedge pclk) disable iff (!prst_n)
    (p_live && !$past(mode)) |-> pipe_q == $past(din));

  p_load_shadow_r4: assert property (@(posedge pclk) disable iff (!prst_n)
    (p_live && $past(mode)) |-> pipe_q == $past(shadow_q));

  p_capture_r5: assert property (@(posedge dclk) disable iff (!drst_n)
    (d_live && $past(mode) && !$past(sdi)) |-> shadow_q == $past(pipe_q));

  p_hold_r6: assert property (@(posedge dclk) disable iff (!drst_n)
    (d_live && $past(mode) && $past(sdi)) |-> $stable(shadow_q));

  p_pin_drive_r6: assert property (@(posedge dclk) disable iff (!drst_n)
    dout_en == (mode && sdi));

  p_y_en_r7: assert property (@(posedge pclk) disable iff (!prst_n)
    (y_en != oe_n) && (y == pipe_q));

  p_sdo_r8: assert property (@(posedge dclk) disable iff (!drst_n)
    sdo == (mode ? sdi : shadow_q[W-1]));
endmodule

bind scan_pipe_reg scan_pipe_reg_chk #(.W(W)) chk_i (
  .pclk(pclk), .prst_n(prst_n), .dclk(dclk), .drst_n(drst_n),
  .mode(mode), .sdi(sdi), .din(din), .dout(dout), .dout_en(dout_en),
  .oe_n(oe_n), .y(y), .y_en(y_en), .sdo(sdo),
  .pipe_q(pipe_q), .shadow_q(shadow_q)
);

// File: tb/scan_pipe_reg_tb_top.sv
module scan_pipe_reg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;
  localparam int NV = 10;
  // entry: {mode, sdi, din[7:0], pulse_pclk, pulse_dclk}
  localparam logic [11:0] VECS [NV] = '{
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b1},
    {1'b0, 1'b0, 8'h00, 1'b0, 1'b1},
    {1'b0, 1'b1, 8'h5A, 1'b1, 1'b1},
    {1'b1, 1'b0, 8'h00, 1'b0, 1'b1},
    {1'b0, 1'b0, 8'hC3, 1'b1, 1'b0},
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b0},
    {1'b1, 1'b1, 8'hFF, 1'b0, 1'b1},
    {1'b0, 1'b0, 8'h0F, 1'b1, 1'b1},
    {1'b1, 1'b1, 8'h00, 1'b1, 1'b0},
    {1'b0, 1'b1, 8'h81, 1'b1, 1'b1}
  };

  logic pclk = 0, dclk = 0, prst_n = 0, drst_n = 0;
  logic mode = 0, sdi = 0, oe_n = 0;
  logic [7:0] din = 0;
  logic [7:0] dout, y;
  logic dout_en, y_en, sdo;

  int checks = 0, fails = 0;
  logic [7:0] mp = 0, ms = 0;
  bit done = 0;

  scan_pipe_reg dut_i (
    .pclk(pclk), .prst_n(prst_n), .dclk(dclk), .drst_n(drst_n),
    .mode(mode), .sdi(sdi), .din(din), .dout(dout), .dout_en(dout_en),
    .oe_n(oe_n), .y(y), .y_en(y_en), .sdo(sdo)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic pp, input logic pd);
    #HALF;
    if (pp) pclk = 1;
    if (pd) dclk = 1;
    #HALF;
    pclk = 0;
    dclk = 0;
  endtask

  // R6: expose shadow on dout via hold setting, no clock
  task automatic peek(input string tag, input logic [7:0] exp);
    logic sm, ss;
    sm = mode; ss = sdi;
    mode = 1; sdi = 1; #1;
    chk({tag, " R6 dout_en"}, {7'd0, dout_en}, 8'd1);
    chk(tag, dout, exp);
    mode = sm; sdi = ss; #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] np, ns, got;
    #3;
    // R1 reset state
    chk("R1 pipe reset", y, 8'h00);
    peek("R1 shadow reset", 8'h00);
    prst_n = 1; drst_n = 1; #2;

    // table walk against bench model
    for (int i = 0; i < NV; i++) begin
      logic vm, vs, vp, vd;
      logic [7:0] vdin;
      {vm, vs, vdin, vp, vd} = VECS[i];
      mode = vm; sdi = vs; din = vdin;
      np = mp; ns = ms;
      if (vp) np = vm ? ms : vdin;
      if (vd) begin
        if (!vm)     ns = {ms[6:0], vs};
        else if (!vs) ns = mp;
      end
      step(vp, vd);
      mp = np; ms = ns;
      #1;
      chk(vm ? "R4 vector y" : "R3 vector y", y, mp);
      peek(vm ? (vs ? "R6 vector shadow" : "R5 vector shadow") : "R2 vector shadow", ms);
    end

    // R7 output enable
    oe_n = 1; #1; chk("R7 y_en off", {7'd0, y_en}, 8'd0);
    oe_n = 0; #1; chk("R7 y_en on", {7'd0, y_en}, 8'd1);
    // R6: shifting mode does not drive pins
    mode = 0; #1; chk("R6 dout_en low", {7'd0, dout_en}, 8'd0);

    // R8 serial output paths
    mode = 1; sdi = 1; #1; chk("R8 pass high", {7'd0, sdo}, 8'd1);
    sdi = 0; #1; chk("R8 pass low", {7'd0, sdo}, 8'd0);
    mode = 0; #1; chk("R8 msb", {7'd0, sdo}, {7'd0, ms[7]});

    // R9 simultaneous swap
    mode = 0; din = 8'h11; step(1, 0);
    for (int b = 7; b >= 0; b--) begin sdi = 8'hEE >> b; step(0, 1); end
    mode = 1; sdi = 0; step(1, 1); #1;
    chk("R9 swap y", y, 8'hEE);
    peek("R9 swap shadow", 8'h11);

    // R1 one domain reset leaves the other
    #1; prst_n = 0; #1;
    chk("R1 pipe cleared", y, 8'h00);
    peek("R1 shadow kept", 8'h11);
    prst_n = 1; #1;

    // R10 round trip: scan in A5, apply, then capture 3C and scan out
    mode = 0;
    for (int b = 7; b >= 0; b--) begin sdi = 8'hA5 >> b; step(0, 1); end
    mode = 1; sdi = 0; step(1, 0); #1;
    chk("R10 applied", y, 8'hA5);
    mode = 0; din = 8'h3C; step(1, 0);
    mode = 1; sdi = 0; step(0, 1);
    mode = 0; sdi = 0; got = 0;
    for (int b = 0; b < 8; b++) begin
      #1; got = {got[6:0], sdo};
      step(0, 1);
    end
    chk("R10 scanned out", got, 8'h3C);

    // R1 shadow reset mid-run keeps pipeline
    drst_n = 0; #1;
    peek("R1 shadow cleared", 8'h00);
    chk("R1 pipe kept", y, 8'h3C);
    drst_n = 1; #1;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule